// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Causes

A bank of 32 general-purpose lines behind a small memory-mapped register interface. Each line can be an output driven from an output latch or an input. Inputs pass through a two-flop synchroniser, and a per-line polarity bit can invert them. The polarity-corrected value is what software reads as data-in and what the interrupt logic sees.

Two interrupt sources exist per line. A level source is the polarity-corrected input itself, with no storage. An edge source is a sticky cause bit set by a 0-to-1 transition of the polarity-corrected input, so the polarity bit selects a rising or a falling edge. Software clears cause bits by writing zeros. Separate edge and level masks gate each source. The gated sources are ORed per line, then ORed in groups of eight lines into four summary interrupt outputs. Blink enable and blink counter select bits are only stored here and exported to an external blink engine.

The bus is single-cycle. A write takes effect at the clock edge where `bus_valid_i` and `bus_write_i` are high. A read returns data combinationally in the same cycle while `bus_valid_i` is high and `bus_write_i` is low.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output, polarity, edge cause, edge mask, level mask, blink enable and blink select registers are zero, the direction register is all ones, and every irq_o bit is 0.
- R2: The register offsets are: output 0x00, direction 0x04, blink enable 0x08, polarity 0x0C, data-in 0x10 (read-only), edge cause 0x14, edge mask 0x18, level mask 0x1C, blink select 0x20. Writable registers read back what was written. A write to 0x10 changes nothing. Unmapped offsets, and any access without a valid read, return 0.
- R3: pin_oe_o bit n is 1 exactly when direction bit n is 0, and pin_o equals the output register.
- R4: Data-in bit n equals pin_i bit n XOR polarity bit n. A pin change appears on data-in after the second rising clock edge.
- R5: An edge cause bit is set only by a 0-to-1 transition of its data-in bit, and it becomes visible after the clock edge following the one that updated data-in. With polarity 1, a falling pin edge sets the bit and a rising one does not.
- R6: Writing the edge cause register clears each bit written 0 and keeps each bit written 1.
- R7: If a cause bit is set by an edge and cleared by a write in the same cycle, it ends up set.
- R8: The level source of a line is its current data-in bit ANDed with the level mask. It drops as soon as data-in drops, with no latching.
- R9: irq_o[g] is the OR over lines 8g to 8g+7 of (edge cause AND edge mask) OR (data-in AND level mask).
- R10: blink_en_o and blink_sel_o equal the blink enable and blink select registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| pin_i | input | 32 | Pad inputs, asynchronous |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| blink_en_o | output | 32 | Per-line blink enable |
| blink_sel_o | output | 32 | Per-line blink counter select |
| irq_o | output | 4 | Summary interrupts, one per group of eight lines |

## Verification
The hardest case is a cause-clearing write that lands on the exact edge where a newly synchronised transition sets the same bit. Because the edge detector sits two synchroniser stages and one history flop behind the pad, the stimulus changes the pin, waits a counted number of falling edges, and then issues the clearing write, so that both events meet on the third rising edge. The same write also clears a different, already set bit to show that the clear itself works. A behavioural model with its own synchroniser history is compared on every cycle, which also catches the spurious edge that appears when the polarity of a low pin is flipped.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    OFS_OUT   = 6'h00,
    OFS_DIR   = 6'h04,
    OFS_BLINK = 6'h08,
    OFS_POL   = 6'h0C,
    OFS_DIN   = 6'h10,
    OFS_CAUSE = 6'h14,
    OFS_EMASK = 6'h18,
    OFS_LMASK = 6'h1C,
    OFS_BSEL  = 6'h20
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_keep_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] prev_q, cause_q, rise, keep;

  assign rise = level_i & ~prev_q;
  assign keep = clr_en_i ? clr_keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= level_i;
      cause_q <= (cause_q & keep) | rise;  // set beats clear
    end
  end

  assign cause_o = cause_q;

  // R5
  cause_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise == '0) |=> ((cause_q & ~$past(cause_q)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((cause_q & ~$past(clr_keep_i) & ~$past(rise)) == '0));
endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = WIDTH / GROUP_SIZE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIDTH-1:0]      src_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign irq_o[g] = |src_i[g*GROUP_SIZE +: GROUP_SIZE];
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (irq_o == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [NUM_PINS-1:0]   bus_wdata_i,
  output logic [NUM_PINS-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   blink_en_o,
  output logic [NUM_PINS-1:0]   blink_sel_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, blink_q, pol_q, bsel_q, emask_q, lmask_q;
  logic [NUM_PINS-1:0] pin_sync, data_in, cause, irq_src;
  logic wr, rd;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      bsel_q  <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        OFS_OUT:   out_q   <= bus_wdata_i;
        OFS_DIR:   dir_q   <= bus_wdata_i;
        OFS_BLINK: blink_q <= bus_wdata_i;
        OFS_POL:   pol_q   <= bus_wdata_i;
        OFS_EMASK: emask_q <= bus_wdata_i;
        OFS_LMASK: lmask_q <= bus_wdata_i;
        OFS_BSEL:  bsel_q  <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  assign data_in = pin_sync ^ pol_q;

  gpio_edge_cause #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (data_in),
    .clr_en_i   (wr && (bus_addr_i == OFS_CAUSE)),
    .clr_keep_i (bus_wdata_i),
    .cause_o    (cause)
  );

  assign irq_src = (cause & emask_q) | (data_in & lmask_q);

  gpio_irq_reduce #(.WIDTH(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_reduce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src),
    .irq_o  (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        OFS_OUT:   bus_rdata_o = out_q;
        OFS_DIR:   bus_rdata_o = dir_q;
        OFS_BLINK: bus_rdata_o = blink_q;
        OFS_POL:   bus_rdata_o = pol_q;
        OFS_DIN:   bus_rdata_o = data_in;
        OFS_CAUSE: bus_rdata_o = cause;
        OFS_EMASK: bus_rdata_o = emask_q;
        OFS_LMASK: bus_rdata_o = lmask_q;
        OFS_BSEL:  bus_rdata_o = bsel_q;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign pin_o       = out_q;
  assign pin_oe_o    = ~dir_q;
  assign blink_en_o  = blink_q;
  assign blink_sel_o = bsel_q;

  // R2
  din_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_DIN) |=> ($stable(out_q) && $stable(dir_q) && $stable(pol_q)
                                       && $stable(emask_q) && $stable(lmask_q)));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, pin_o, pin_oe, blink_en, blink_sel;
  logic [3:0]  irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .blink_en_o(blink_en), .blink_sel_o(blink_sel), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_out, m_dir, m_blk, m_pol, m_bsel, m_em, m_lm, m_cause, m_s1, m_s2, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = '1; m_blk = 0; m_pol = 0; m_bsel = 0; m_em = 0; m_lm = 0;
      m_cause = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      logic [31:0] din, keep;
      din = m_s2 ^ m_pol;
      keep = (valid && write && addr == 6'h14) ? wdata : '1;
      m_cause = (m_cause & keep) | (din & ~m_prev);
      m_prev = din;
      m_s2 = m_s1;
      m_s1 = pins;
      if (valid && write) begin
        case (addr)
          6'h00: m_out = wdata;
          6'h04: m_dir = wdata;
          6'h08: m_blk = wdata;
          6'h0C: m_pol = wdata;
          6'h18: m_em = wdata;
          6'h1C: m_lm = wdata;
          6'h20: m_bsel = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read();
    if (!(valid && !write)) return 0;
    case (addr)
      6'h00: return m_out;   6'h04: return m_dir;
      6'h08: return m_blk;   6'h0C: return m_pol;
      6'h10: return m_s2 ^ m_pol;
      6'h14: return m_cause; 6'h18: return m_em;
      6'h1C: return m_lm;    6'h20: return m_bsel;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] m_irq();
    logic [31:0] s;
    logic [3:0] r;
    s = (m_cause & m_em) | ((m_s2 ^ m_pol) & m_lm);
    for (int g = 0; g < 4; g++) r[g] = |s[g*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      chk("R2 rdata vs model", rdata, m_read());
      chk("R9 irq vs model", {28'd0, irq}, {28'd0, m_irq()});
      chk("R3 pin_o vs model", pin_o, m_out);
      chk("R3 pin_oe vs model", pin_oe, ~m_dir);
      chk("R10 blink vs model", blink_en ^ blink_sel, m_blk ^ m_bsel);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); valid = 1; write = 0; addr = a;
    #2 chk(req, rdata, exp);
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk); valid = 0; pins = p;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h00, 32'h0, "R1 output reset");
    rd(6'h04, 32'hFFFF_FFFF, "R1 direction reset");
    rd(6'h14, 32'h0, "R1 cause reset");
    rd(6'h18, 32'h0, "R1 edge mask reset");
    rd(6'h1C, 32'h0, "R1 level mask reset");
    chk("R1 irq reset", {28'd0, irq}, 32'h0);
    chk("R1 oe reset", pin_oe, 32'h0);
    // R2/R3 output and direction
    wr(6'h00, 32'hA5A5_0F0F);
    wr(6'h04, 32'h0000_FFFF);
    rd(6'h00, 32'hA5A5_0F0F, "R2 output readback");
    rd(6'h04, 32'h0000_FFFF, "R2 direction readback");
    chk("R3 pin_o", pin_o, 32'hA5A5_0F0F);
    chk("R3 pin_oe", pin_oe, 32'hFFFF_0000);
    // R10 blink storage
    wr(6'h08, 32'h0000_00F0);
    wr(6'h20, 32'h1234_5678);
    chk("R10 blink_en_o", blink_en, 32'h0000_00F0);
    chk("R10 blink_sel_o", blink_sel, 32'h1234_5678);
    rd(6'h20, 32'h1234_5678, "R2 blink select readback");
    // R2 ignored write and unmapped offset
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0, "R2 data-in write ignored");
    rd(6'h00, 32'hA5A5_0F0F, "R2 output kept after data-in write");
    rd(6'h24, 32'h0, "R2 unmapped offset");
    // R4 two-stage delay
    set_pins(32'h0000_0003);
    rd(6'h10, 32'h0, "R4 data-in after one edge");
    rd(6'h10, 32'h3, "R4 data-in after two edges");
    rd(6'h14, 32'h3, "R5 rising edge latched");
    // R6 clear by zero
    wr(6'h14, ~32'h1);
    rd(6'h14, 32'h2, "R6 clear bit0 keep bit1");
    // R5 falling edge with polarity set
    wr(6'h0C, 32'h0000_0100);
    tick(3);
    wr(6'h14, ~32'h100);  // drop edge caused by the polarity flip
    rd(6'h14, 32'h2, "R6 clear polarity-flip edge");
    set_pins(32'h0000_0103);
    tick(4);
    rd(6'h10, 32'h0000_0003, "R4 inverted pin reads low");
    rd(6'h14, 32'h2, "R5 rising pin ignored with polarity 1");
    set_pins(32'h0000_0003);
    tick(4);
    rd(6'h14, 32'h0000_0102, "R5 falling pin sets cause with polarity 1");
    // R7 set and clear collide
    set_pins(32'h0001_0003);
    @(negedge clk);
    wr(6'h14, ~32'h0001_0002);
    rd(6'h14, 32'h0001_0100, "R7 set wins, other bit cleared");
    // R9 edge masking and grouping
    wr(6'h18, 32'h0001_0000);
    chk("R9 group2 from edge", {28'd0, irq}, 32'h4);
    wr(6'h18, 32'h0000_0100);
    chk("R9 group1 from edge", {28'd0, irq}, 32'h2);
    wr(6'h18, 32'h0);
    chk("R9 edge mask off", {28'd0, irq}, 32'h0);
    // R8 level without latch
    wr(6'h1C, 32'h8000_0000);
    set_pins(32'h8001_0003);
    tick(3);
    chk("R8 level high", {28'd0, irq}, 32'h8);
    set_pins(32'h0001_0003);
    tick(3);
    chk("R8 level drops", {28'd0, irq}, 32'h0);
    wr(6'h1C, 32'h0000_0003);
    chk("R9 group0 from level", {28'd0, irq}, 32'h1);
    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule